// File: doc/BRIEF.md
# RTC Extended Status and Control Register

This block is one 8-bit register of a real-time clock's secondary register bank. It holds the sticky event flags for wake-up, kickstart and RAM-clear. It shows battery health and an update-in-progress indication. It also holds a burst-mode enable, a spare storage bit and the control bit for an open-drain power pin. It connects to a simple parallel bus: a select that marks an address match, read and write strobes, and byte-wide write and read data.

Event inputs arrive as one-cycle pulses. The exception is the RAM-clear pin, which is asynchronous and active low. It passes through a two-flop synchroniser, and its falling edge is detected in the system clock domain. The increment indication is kept by a small state machine with two states. **INC_IDLE** moves to **INC_BUSY** on the early-warning pulse (transition *warn*). **INC_BUSY** returns to **INC_IDLE** on the end-of-update pulse (transition *done*). The timer that produces these pulses lies outside this block. The power-control bit clears itself while any enabled wake-up or kickstart flag is pending. This lets an alarm switch the system power on.

Top module: `rtc_xctl_reg`

## Requirements
- R1: After reset, the register reads 0x08 with `bat_ok_i` low (0x88 with it high). The power pin is released (`pwr_hiz_o`=1), `burst_en_o`=0 and `irq_o`=0.
- R2: A read with `sel_i` and `rd_i` high returns bit 7 battery, bit 6 increment, bit 5 burst enable, bit 4 spare, bit 3 power control, bit 2 RAM-clear flag, bit 1 wake flag and bit 0 kickstart flag. When no read is selected, `rdata_o` is 0x00.
- R3: Bit 7 always equals `bat_ok_i`. Writes to bit 7 have no effect.
- R4: Bit 6 becomes 1 on the clock after a `upd_warn_i` pulse (INC_IDLE to INC_BUSY). It returns to 0 on the clock after a `upd_done_i` pulse (INC_BUSY to INC_IDLE). No other input changes it.
- R5: Bit 5 is read/write, and `burst_en_o` follows it.
- R6: Bit 4 is read/write storage. Its value changes no output.
- R7: Bit 3 is read/write, and `pwr_hiz_o` follows it. A value of 1 releases the pin; a value of 0 asks for it to be driven low.
- R8: While (wake flag AND `wf_ie_i`) OR (kickstart flag AND `kf_ie_i`) holds, bit 3 is forced to 0 on the next clock. A write of 1 to bit 3 is ignored in that state.
- R9: A `wake_evt_i` or `kick_evt_i` pulse sets its flag on the next clock. Writing 0 clears a flag, and writing 1 sets it.
- R10: The RAM-clear flag sets on a high-to-low edge of `ramclr_n_i`, seen through two synchroniser flops, when `ramclr_en_i` is 1. With `ramclr_en_i` at 0 the edge is ignored.
- R11: A hardware set and a write of 0 to the same flag in the same cycle leave the flag at 1.
- R12: `irq_o` is the OR of each flag ANDed with its own enable (`rf_ie_i`, `wf_ie_i`, `kf_ie_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sel_i | input | 1 | Address match for this register |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| bat_ok_i | input | 1 | Auxiliary battery present |
| upd_warn_i | input | 1 | Pulse ahead of the update cycle |
| upd_done_i | input | 1 | Pulse at the end of the update cycle |
| wake_evt_i | input | 1 | Wake-up alarm event pulse |
| kick_evt_i | input | 1 | Kickstart event pulse |
| ramclr_n_i | input | 1 | Asynchronous RAM-clear pin, active low |
| ramclr_en_i | input | 1 | Enables RAM-clear edge detection |
| rf_ie_i | input | 1 | RAM-clear interrupt enable |
| wf_ie_i | input | 1 | Wake-up interrupt enable |
| kf_ie_i | input | 1 | Kickstart enable |
| burst_en_o | output | 1 | Burst address auto-increment enable |
| pwr_hiz_o | output | 1 | 1 releases the power pin, 0 drives it low |
| irq_o | output | 1 | Interrupt request |

## Verification
The flags are driven from three sources: hardware pulses, writes of 1 and writes of 0. A write of 0 is also placed in the same cycle as a set pulse. This shows whether set and clear are separate paths and whether the set wins. The power bit is tried in three ways: a plain write, a write of 1 while an enabled flag is pending, and a write after the flag is cleared. These show the forcing apart from a mere write failure. RAM-clear edges are applied with the enable on and then off. Battery and spare bits are written against their read-only or no-effect rules.

// File: rtl/rtc_xctl_pkg.sv
package rtc_xctl_pkg;
    localparam int REG_W   = 8;
    localparam int NFLAG   = 3;
    localparam int B_BAT   = 7;
    localparam int B_INC   = 6;
    localparam int B_BME   = 5;
    localparam int B_SPARE = 4;
    localparam int B_PWR   = 3;
    localparam int B_RF    = 2;
    localparam int B_WF    = 1;
    localparam int B_KF    = 0;
    localparam int F_KF    = 0;
    localparam int F_WF    = 1;
    localparam int F_RF    = 2;

    typedef enum logic [0:0] {
        INC_IDLE = 1'b0,
        INC_BUSY = 1'b1
    } inc_state_e;
endpackage

// File: rtl/rtc_xctl_fall_sync.sv
module rtc_xctl_fall_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= {sh_q[LAST-1:0], pin_i};
        end
    end

    // Previous synchronised sample high, current one low.
    assign fall_o = sh_q[LAST] & ~sh_q[LAST-1];

    // R10: an edge is a single-cycle event
    assert_fall_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/rtc_xctl_incr_fsm.sv
module rtc_xctl_incr_fsm
    import rtc_xctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic warn_i,
    input  logic done_i,
    output logic busy_o
);
    inc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            INC_IDLE: if (warn_i) state_d = INC_BUSY;
            INC_BUSY: if (done_i) state_d = INC_IDLE;
            default:  state_d = INC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= INC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy_o = (state_q == INC_BUSY);
    end

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !warn_i) |=> !busy_o);
    assert_busy_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && done_i) |=> !busy_o);
    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_i) |=> busy_o);
endmodule

// File: rtl/rtc_xctl_flag.sv
module rtc_xctl_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic we_i,
    input  logic wbit_i,
    output logic q_o
);
    logic q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (we_i)  q <= wbit_i;
    end

    assign q_o = q;

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !wbit_i && !set_i) |=> !q_o);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/rtc_xctl_reg.sv
module rtc_xctl_reg
    import rtc_xctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    input  logic             bat_ok_i,
    input  logic             upd_warn_i,
    input  logic             upd_done_i,
    input  logic             wake_evt_i,
    input  logic             kick_evt_i,
    input  logic             ramclr_n_i,
    input  logic             ramclr_en_i,
    input  logic             rf_ie_i,
    input  logic             wf_ie_i,
    input  logic             kf_ie_i,
    output logic             burst_en_o,
    output logic             pwr_hiz_o,
    output logic             irq_o
);
    logic             we;
    logic             ramclr_fall;
    logic             incr_busy;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_wbit;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] flag_ie;
    logic             pwr_force;
    logic             bme_q, spare_q, pwr_q;

    assign we = sel_i & wr_i;

    rtc_xctl_fall_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ramclr_n_i),
        .fall_o (ramclr_fall)
    );

    rtc_xctl_incr_fsm u_incr (
        .clk    (clk),
        .rst_n  (rst_n),
        .warn_i (upd_warn_i),
        .done_i (upd_done_i),
        .busy_o (incr_busy)
    );

    assign flag_set[F_KF]  = kick_evt_i;
    assign flag_set[F_WF]  = wake_evt_i;
    assign flag_set[F_RF]  = ramclr_fall & ramclr_en_i;
    assign flag_wbit       = wdata_i[B_RF:B_KF];
    assign flag_ie[F_KF]   = kf_ie_i;
    assign flag_ie[F_WF]   = wf_ie_i;
    assign flag_ie[F_RF]   = rf_ie_i;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        rtc_xctl_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[g]),
            .we_i   (we),
            .wbit_i (flag_wbit[g]),
            .q_o    (flag_q[g])
        );
    end

    assign pwr_force = (flag_q[F_WF] & wf_ie_i) | (flag_q[F_KF] & kf_ie_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bme_q   <= 1'b0;
            spare_q <= 1'b0;
            pwr_q   <= 1'b1;
        end else begin
            if (we) begin
                bme_q   <= wdata_i[B_BME];
                spare_q <= wdata_i[B_SPARE];
            end
            if (pwr_force) pwr_q <= 1'b0;
            else if (we)   pwr_q <= wdata_i[B_PWR];
        end
    end

    assign burst_en_o = bme_q;
    assign pwr_hiz_o  = pwr_q;
    assign irq_o      = |(flag_q & flag_ie);
    assign rdata_o    = (sel_i && rd_i) ?
        {bat_ok_i, incr_busy, bme_q, spare_q, pwr_q, flag_q[F_RF], flag_q[F_WF], flag_q[F_KF]}
        : '0;

    assert_pwr_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((wake_evt_i && wf_ie_i && $stable(wf_ie_i)) ##1 wf_ie_i) |=> !pwr_hiz_o);
    assert_rf_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ramclr_en_i && !we && !rdata_o[B_RF] && !flag_q[F_RF]) |=> !flag_q[F_RF]);
    assert_bme_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (burst_en_o == $past(wdata_i[B_BME])));
    assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i && rd_i) |-> (rdata_o == '0));
endmodule

// File: tb/rtc_xctl_reg_tb.sv
module rtc_xctl_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 0, rd = 0, wr = 0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       bat_ok = 1, upd_warn = 0, upd_done = 0, wake_evt = 0, kick_evt = 0;
    logic       ramclr_n = 1, ramclr_en = 0, rf_ie = 0, wf_ie = 0, kf_ie = 0;
    logic       burst_en, pwr_hiz, irq;
    int         total = 0;
    int         bad = 0;
    logic       finished = 0;

    always #2 clk = ~clk;

    rtc_xctl_reg dut_i (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .rd_i(rd), .wr_i(wr),
        .wdata_i(wdata), .rdata_o(rdata), .bat_ok_i(bat_ok),
        .upd_warn_i(upd_warn), .upd_done_i(upd_done),
        .wake_evt_i(wake_evt), .kick_evt_i(kick_evt),
        .ramclr_n_i(ramclr_n), .ramclr_en_i(ramclr_en),
        .rf_ie_i(rf_ie), .wf_ie_i(wf_ie), .kf_ie_i(kf_ie),
        .burst_en_o(burst_en), .pwr_hiz_o(pwr_hiz), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk); sel = 1; wr = 1; wdata = v;
        @(negedge clk); sel = 0; wr = 0; wdata = '0;
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk); sel = 1; rd = 1;
        #1 v = rdata;
        sel = 0; rd = 0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake_evt = 1;
        @(negedge clk); wake_evt = 0;
    endtask

    task automatic pulse_kick();
        @(negedge clk); kick_evt = 1;
        @(negedge clk); kick_evt = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R2 idle rdata", rdata, 8'h00);
        chk("R1 pwr_hiz", {7'd0, pwr_hiz}, 8'h01);
        chk("R1 burst_en", {7'd0, burst_en}, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        do_read(v); chk("R1 reset value", v, 8'h88);
    endtask

    task automatic t_layout();
        logic [7:0] v;
        do_write(8'h30);
        do_read(v); chk("R2 R5 R6 readback 30", v, 8'hB0);
        chk("R5 burst_en on", {7'd0, burst_en}, 8'h01);
        chk("R7 pwr_hiz low after write 0", {7'd0, pwr_hiz}, 8'h00);
        chk("R6 spare has no effect on irq", {7'd0, irq}, 8'h00);
        do_write(8'h08);
        do_read(v); chk("R5 R7 readback 08", v, 8'h88);
        chk("R7 pwr_hiz released", {7'd0, pwr_hiz}, 8'h01);
        chk("R5 burst_en off", {7'd0, burst_en}, 8'h00);
    endtask

    task automatic t_battery();
        logic [7:0] v;
        bat_ok = 0;
        do_write(8'h88);
        do_read(v); chk("R3 battery low, write ignored", v, 8'h08);
        bat_ok = 1;
        do_read(v); chk("R3 battery high", v, 8'h88);
    endtask

    task automatic t_incr();
        logic [7:0] v;
        @(negedge clk); upd_warn = 1;
        @(negedge clk); upd_warn = 0;
        do_read(v); chk("R4 incr set after warn", v, 8'hC8);
        repeat (3) @(negedge clk);
        do_read(v); chk("R4 incr holds", v, 8'hC8);
        @(negedge clk); upd_done = 1;
        @(negedge clk); upd_done = 0;
        do_read(v); chk("R4 incr clear after done", v, 8'h88);
    endtask

    task automatic t_flags();
        logic [7:0] v;
        pulse_wake();
        do_read(v); chk("R9 wake flag set by event", v, 8'h8A);
        chk("R12 irq masked", {7'd0, irq}, 8'h00);
        wf_ie = 1; #1;
        chk("R12 irq wake enabled", {7'd0, irq}, 8'h01);
        wf_ie = 0;
        pulse_kick();
        do_read(v); chk("R9 kick flag set by event", v, 8'h8B);
        do_write(8'h08);
        do_read(v); chk("R9 flags cleared by write 0", v, 8'h88);
        do_write(8'h0F);
        do_read(v); chk("R9 flags forced by write 1", v, 8'h8F);
        rf_ie = 1; #1;
        chk("R12 irq from forced RAM-clear flag", {7'd0, irq}, 8'h01);
        rf_ie = 0;
        do_write(8'h08);
    endtask

    task automatic t_ramclr();
        logic [7:0] v;
        ramclr_en = 1;
        @(negedge clk); ramclr_n = 0;
        repeat (4) @(negedge clk);
        do_read(v); chk("R10 RAM-clear flag on falling edge", v, 8'h8C);
        ramclr_n = 1;
        repeat (4) @(negedge clk);
        do_write(8'h08);
        ramclr_en = 0;
        @(negedge clk); ramclr_n = 0;
        repeat (4) @(negedge clk);
        do_read(v); chk("R10 edge ignored when disabled", v, 8'h88);
        ramclr_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_pwr_force();
        logic [7:0] v;
        wf_ie = 1;
        pulse_wake();
        @(negedge clk);
        chk("R8 pwr forced low by wake", {7'd0, pwr_hiz}, 8'h00);
        do_write(8'h0A);
        do_read(v); chk("R8 write 1 ignored while pending", v, 8'h82);
        do_write(8'h08);
        do_read(v); chk("R8 flag cleared", v, 8'h80);
        do_write(8'h08);
        chk("R7 pwr writable after clear", {7'd0, pwr_hiz}, 8'h01);
        wf_ie = 0;
        kf_ie = 1;
        pulse_kick();
        @(negedge clk);
        chk("R8 pwr forced low by kick", {7'd0, pwr_hiz}, 8'h00);
        do_write(8'h08);
        do_write(8'h08);
        kf_ie = 0;
        chk("R8 pwr released", {7'd0, pwr_hiz}, 8'h01);
        pulse_kick();
        @(negedge clk);
        chk("R8 no force when enable off", {7'd0, pwr_hiz}, 8'h01);
        do_write(8'h08);
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        @(negedge clk); sel = 1; wr = 1; wdata = 8'h08; wake_evt = 1; kick_evt = 1;
        @(negedge clk); sel = 0; wr = 0; wdata = '0; wake_evt = 0; kick_evt = 0;
        do_read(v); chk("R11 set beats write 0", v, 8'h8B);
        do_write(8'h08);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_layout();
        t_battery();
        t_incr();
        t_flags();
        t_ramclr();
        t_pwr_force();
        t_set_wins();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule